// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block decides which of five interrupt sources an 8-bit processor core services next. The sources are:

- a non-maskable line;
- three maskable restart request lines (low, middle and high) that branch to fixed vector addresses;
- one general external request, whose vector arrives later during an external acknowledge bus cycle.

The block holds the global interrupt enable, one mask bit per restart line, and the capture flops. Those flops are edge-triggered for the high restart line and edge-armed with a level check for the non-maskable line. It also holds the serial output bit.

The core pulses `sample_i` in the sampling windows: the next-to-last clock of each instruction, and every clock of hold or halt. On such an edge the block picks the highest-priority eligible source. One clock later it presents a one-cycle `take_o` pulse with the vector address. When the external request won, it also presents a one-cycle `ack_cycle_o` pulse. The core executes enable and disable instructions through `ei_i` and `di_i`. It writes the mask word through `mask_wr_i` and reads the status word combinationally on `stat_rdata_o`. The core pulses `stat_rd_i` when it consumes a status read.

The asynchronous active-low reset is released to the logic through a two-stage synchronizer. All other inputs are assumed to be synchronous to `clk`.

Top module: `irq_restart_ctrl`

## Requirements
- R1: After reset, all three masks are set, the enable is clear, the serial output is 0, no request is captured and `take_o`/`ack_cycle_o` are low; the status word therefore reads 0x07 with the serial input low and no level requests.
- R2: When several sources are eligible at a sampling edge, exactly one is taken, in the order non-maskable, high, middle, low, external (highest first).
- R3: Vector addresses are 0x24 for the non-maskable line, 0x3C for high, 0x34 for middle and 0x2C for low; an external-request take reports vector 0x00.
- R4: A source is taken only on a clock edge where `sample_i` is high; `take_o` rises in the following cycle and lasts one cycle.
- R5: A rising edge on the high restart line sets its capture flop even while that line is masked; the flop is visible in status bit 6 and is serviced once the mask is cleared and the enable is set.
- R6: The high capture flop is cleared when its request is taken, or by a mask write with bit 4 set.
- R7: The low and middle restart lines and the external request are level-sensitive: a line that has dropped before the sampling edge is not taken.
- R8: The non-maskable line is taken regardless of masks and enable; after a take it is not taken again until it has gone low and then high.
- R9: A non-maskable edge whose line returns low before the sampling edge is discarded.
- R10: A take clears the enable; `ei_i` sets it and `di_i` clears it; a take in the same cycle as `ei_i` leaves it clear.
- R11: On a non-maskable take the prior enable is saved; status bit 3 shows that saved value until the first `stat_rd_i` pulse, and after that shows the live enable.
- R12: Mask write word: bits 2:0 are the masks for low, middle and high, loaded only when bit 3 is 1; bit 6 is the serial output value, loaded only when bit 7 is 1.
- R13: Status word: bits 2:0 masks (low, middle, high), bit 3 enable, bit 4 low line, bit 5 middle line, bit 6 high capture flop, bit 7 serial input pin.
- R14: The external request is taken only while the enable is set, and its take raises `ack_cycle_o` together with `take_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request line |
| rq_hi_i | input | 1 | High restart line, edge-captured |
| rq_mid_i | input | 1 | Middle restart line, level |
| rq_lo_i | input | 1 | Low restart line, level |
| ext_req_i | input | 1 | General external request, level |
| sample_i | input | 1 | Sampling window strobe from the core |
| ei_i | input | 1 | Enable-interrupts instruction strobe |
| di_i | input | 1 | Disable-interrupts instruction strobe |
| mask_wr_i | input | 1 | Mask word write strobe |
| mask_wdata_i | input | 8 | Mask word |
| stat_rd_i | input | 1 | Status read consumed strobe |
| stat_rdata_o | output | 8 | Status word |
| serial_in_i | input | 1 | Serial input pin |
| serial_out_o | output | 1 | Serial output bit |
| take_o | output | 1 | Interrupt taken pulse |
| ack_cycle_o | output | 1 | External acknowledge cycle request pulse |
| vec_o | output | 8 | Vector address of the last take |

## Verification
The bench aims at the capture and arming rules, where a design error changes which source is taken, not merely when.

- A masked edge on the high line must survive until the mask is cleared. A design that gated capture with the mask would lose that request.
- A non-maskable line held high after service must not be taken twice. A pure level detector would take it again on every sampling edge.
- A non-maskable pulse that ends before sampling must be dropped. A design without the level check would take it.
- The first status read after a non-maskable take must show the enable saved before the take. A design without the save would report the cleared value.
- A take must win over `ei_i` in the same cycle. Reversed precedence would leave interrupts enabled inside the service routine.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam int NUM_RQ = 3;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] NMI_VEC = 8'h24;
  localparam logic [BYTE_W-1:0] RQ_BASE = 8'h2C;
  localparam int                RQ_STEP = 8;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_EXT  = 3'd1,
    SRC_LO   = 3'd2,
    SRC_MID  = 3'd3,
    SRC_HI   = 3'd4,
    SRC_NMI  = 3'd5
  } irq_src_e;

  // Restart vectors are evenly spaced from the lowest-priority line upward.
  function automatic logic [BYTE_W-1:0] rq_vector(input int idx);
    return RQ_BASE + BYTE_W'(idx * RQ_STEP);
  endfunction

endpackage

// File: rtl/irq_edge_flag.sv
module irq_edge_flag #(
  parameter bit LEVEL_QUAL = 1'b0,
  parameter bit PREV_INIT  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic clr_i,
  output logic flag_o
);

  logic prev_q, prev_d;
  logic flag_q, flag_d;

  always_comb begin
    prev_d = pin_i;
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (LEVEL_QUAL && !pin_i) flag_d = 1'b0;
    // A fresh rising edge wins over any clear in the same cycle.
    if (pin_i && !prev_q) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= PREV_INIT;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              accept_nmi_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              mask_wr_i,
  input  logic              mask_ld_i,
  input  logic [NUM_RQ-1:0] mask_val_i,
  input  logic              sout_ld_i,
  input  logic              sout_val_i,
  input  logic              stat_rd_i,
  output logic [NUM_RQ-1:0] mask_o,
  output logic              ie_o,
  output logic              ie_view_o,
  output logic              sout_o
);

  logic [NUM_RQ-1:0] mask_q, mask_d;
  logic              ie_q, ie_d;
  logic              saved_q, saved_d;
  logic              note_q, note_d;
  logic              sout_q, sout_d;

  always_comb begin
    mask_d  = mask_q;
    ie_d    = ie_q;
    saved_d = saved_q;
    note_d  = note_q;
    sout_d  = sout_q;

    if (mask_wr_i && mask_ld_i) mask_d = mask_val_i;
    if (mask_wr_i && sout_ld_i) sout_d = sout_val_i;

    if (accept_i)  ie_d = 1'b0;
    else if (di_i) ie_d = 1'b0;
    else if (ei_i) ie_d = 1'b1;

    if (accept_nmi_i) begin
      saved_d = ie_q;
      note_d  = 1'b1;
    end else if (stat_rd_i) begin
      note_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      ie_q    <= 1'b0;
      saved_q <= 1'b0;
      note_q  <= 1'b0;
      sout_q  <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      ie_q    <= ie_d;
      saved_q <= saved_d;
      note_q  <= note_d;
      sout_q  <= sout_d;
    end
  end

  assign mask_o    = mask_q;
  assign ie_o      = ie_q;
  assign ie_view_o = note_q ? saved_q : ie_q;
  assign sout_o    = sout_q;

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_ctl_pkg::*;
(
  input  logic              nmi_pend_i,
  input  logic [NUM_RQ-1:0] rq_pend_i,
  input  logic              ext_pend_i,
  input  logic [NUM_RQ-1:0] mask_i,
  input  logic              ie_i,
  output irq_src_e          win_o,
  output logic [BYTE_W-1:0] vec_o
);

  logic [NUM_RQ-1:0] rq_elig;

  for (genvar k = 0; k < NUM_RQ; k++) begin : g_elig
    assign rq_elig[k] = rq_pend_i[k] & ~mask_i[k] & ie_i;
  end

  // Scan from lowest to highest priority; a later hit overrides.
  always_comb begin
    win_o = SRC_NONE;
    vec_o = '0;
    if (ext_pend_i && ie_i) begin
      win_o = SRC_EXT;
      vec_o = '0;
    end
    for (int k = 0; k < NUM_RQ; k++) begin
      if (rq_elig[k]) begin
        win_o = irq_src_e'(3'(int'(SRC_LO) + k));
        vec_o = rq_vector(k);
      end
    end
    if (nmi_pend_i) begin
      win_o = SRC_NMI;
      vec_o = NMI_VEC;
    end
  end

endmodule

// File: rtl/irq_restart_ctrl.sv
module irq_restart_ctrl
  import irq_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nmi_i,
  input  logic       rq_hi_i,
  input  logic       rq_mid_i,
  input  logic       rq_lo_i,
  input  logic       ext_req_i,
  input  logic       sample_i,
  input  logic       ei_i,
  input  logic       di_i,
  input  logic       mask_wr_i,
  input  logic [7:0] mask_wdata_i,
  input  logic       stat_rd_i,
  output logic [7:0] stat_rdata_o,
  input  logic       serial_in_i,
  output logic       serial_out_o,
  output logic       take_o,
  output logic       ack_cycle_o,
  output logic [7:0] vec_o
);

  localparam int SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[SYNC_STAGES-1];

  // Mask word fields
  logic              mw_mask_ld, mw_hi_clr, mw_sout_val, mw_sout_ld;
  logic [NUM_RQ-1:0] mw_mask_val;
  logic              mw_unused_bit;
  assign mw_mask_val   = mask_wdata_i[NUM_RQ-1:0];
  assign mw_mask_ld    = mask_wdata_i[3];
  assign mw_hi_clr     = mask_wdata_i[4];
  assign mw_unused_bit = mask_wdata_i[5];
  assign mw_sout_val   = mask_wdata_i[6];
  assign mw_sout_ld    = mask_wdata_i[7];

  logic              nmi_flag, hi_flag, hi_clr;
  logic [NUM_RQ-1:0] mask_w;
  logic              ie_w, ie_view_w, sout_w;
  logic [NUM_RQ-1:0] rq_pend;
  irq_src_e          win;
  logic [BYTE_W-1:0] win_vec;
  logic              accept, accept_nmi;

  assign accept     = sample_i && (win != SRC_NONE);
  assign accept_nmi = sample_i && (win == SRC_NMI);
  assign hi_clr     = (accept && win == SRC_HI) || (mask_wr_i && mw_hi_clr);

  irq_edge_flag #(.LEVEL_QUAL(1'b1), .PREV_INIT(1'b1)) u_nmi_flag (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  (nmi_i),
    .clr_i  (accept_nmi),
    .flag_o (nmi_flag)
  );

  irq_edge_flag #(.LEVEL_QUAL(1'b0), .PREV_INIT(1'b1)) u_hi_flag (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  (rq_hi_i),
    .clr_i  (hi_clr),
    .flag_o (hi_flag)
  );

  assign rq_pend = {hi_flag, rq_mid_i, rq_lo_i};

  irq_ctrl_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .accept_i     (accept),
    .accept_nmi_i (accept_nmi),
    .ei_i         (ei_i),
    .di_i         (di_i),
    .mask_wr_i    (mask_wr_i),
    .mask_ld_i    (mw_mask_ld),
    .mask_val_i   (mw_mask_val),
    .sout_ld_i    (mw_sout_ld),
    .sout_val_i   (mw_sout_val),
    .stat_rd_i    (stat_rd_i),
    .mask_o       (mask_w),
    .ie_o         (ie_w),
    .ie_view_o    (ie_view_w),
    .sout_o       (sout_w)
  );

  irq_prio_arb u_arb (
    .nmi_pend_i (nmi_flag && nmi_i),
    .rq_pend_i  (rq_pend),
    .ext_pend_i (ext_req_i),
    .mask_i     (mask_w),
    .ie_i       (ie_w),
    .win_o      (win),
    .vec_o      (win_vec)
  );

  // Output registers
  logic              take_q, take_d;
  logic              ack_q, ack_d;
  logic [BYTE_W-1:0] vec_q, vec_d;

  always_comb begin
    take_d = accept;
    ack_d  = accept && (win == SRC_EXT);
    vec_d  = accept ? win_vec : vec_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      take_q <= 1'b0;
      ack_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= take_d;
      ack_q  <= ack_d;
      vec_q  <= vec_d;
    end
  end

  assign take_o       = take_q;
  assign ack_cycle_o  = ack_q;
  assign vec_o        = vec_q;
  assign serial_out_o = sout_w;
  assign stat_rdata_o = {serial_in_i, hi_flag, rq_mid_i, rq_lo_i, ie_view_w, mask_w};

endmodule

// File: rtl/irq_restart_ctrl_chk.sv
module irq_restart_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_i,
  input logic       nmi_i,
  input logic       mask_wr_i,
  input logic [7:0] mask_wdata_i,
  input logic [7:0] stat_rdata_o,
  input logic       take_o,
  input logic       ack_cycle_o,
  input logic [7:0] vec_o,
  input logic       ie_w
);

  // R4
  take_only_sampled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(sample_i));

  // R10
  ie_cleared_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !ie_w);

  // R14
  ack_with_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_cycle_o |-> (take_o && vec_o == 8'h00));

  // R8
  nmi_vec_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o == 8'h24) |-> $past(nmi_i));

  // R12
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_i && !mask_wdata_i[3]) |=> $stable(stat_rdata_o[2:0]));

  // R3
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (vec_o == 8'h24 || vec_o == 8'h3C || vec_o == 8'h34 ||
                vec_o == 8'h2C || vec_o == 8'h00));

endmodule

bind irq_restart_ctrl irq_restart_ctrl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_i     (sample_i),
  .nmi_i        (nmi_i),
  .mask_wr_i    (mask_wr_i),
  .mask_wdata_i (mask_wdata_i),
  .stat_rdata_o (stat_rdata_o),
  .take_o       (take_o),
  .ack_cycle_o  (ack_cycle_o),
  .vec_o        (vec_o),
  .ie_w         (ie_w)
);

// File: tb/irq_restart_ctrl_tb.sv
module irq_restart_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       nmi_i, rq_hi_i, rq_mid_i, rq_lo_i, ext_req_i;
  logic       sample_i, ei_i, di_i, mask_wr_i, stat_rd_i, serial_in_i;
  logic [7:0] mask_wdata_i;
  logic [7:0] stat_rdata_o, vec_o;
  logic       serial_out_o, take_o, ack_cycle_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  irq_restart_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .rq_hi_i(rq_hi_i),
    .rq_mid_i(rq_mid_i), .rq_lo_i(rq_lo_i), .ext_req_i(ext_req_i),
    .sample_i(sample_i), .ei_i(ei_i), .di_i(di_i), .mask_wr_i(mask_wr_i),
    .mask_wdata_i(mask_wdata_i), .stat_rd_i(stat_rd_i),
    .stat_rdata_o(stat_rdata_o), .serial_in_i(serial_in_i),
    .serial_out_o(serial_out_o), .take_o(take_o), .ack_cycle_o(ack_cycle_o),
    .vec_o(vec_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_ei();   ei_i = 1; tick(); ei_i = 0; endtask
  task automatic pulse_di();   di_i = 1; tick(); di_i = 0; endtask
  task automatic pulse_rd();   stat_rd_i = 1; tick(); stat_rd_i = 0; endtask
  task automatic write_mask(input logic [7:0] w);
    mask_wr_i = 1; mask_wdata_i = w; tick(); mask_wr_i = 0; mask_wdata_i = 0;
  endtask
  // Sample once; result is read one cycle after the sampling edge.
  task automatic sample_once(output logic t, output logic [7:0] v, output logic a);
    sample_i = 1; tick(); sample_i = 0;
    t = take_o; v = vec_o; a = ack_cycle_o;
  endtask

  task automatic t_reset();
    check("R1 take", take_o, 0);
    check("R1 ack", ack_cycle_o, 0);
    check("R1 sout", serial_out_o, 0);
    check("R1 R13 status", stat_rdata_o, 8'h07);
  endtask

  task automatic t_mask_word();
    write_mask(8'h08);
    check("R12 masks loaded", stat_rdata_o[2:0], 0);
    write_mask(8'h05);
    check("R12 masks held without bit3", stat_rdata_o[2:0], 0);
    write_mask(8'hC0);
    check("R12 sout set", serial_out_o, 1);
    write_mask(8'h40);
    check("R12 sout held without bit7", serial_out_o, 1);
    write_mask(8'h80);
    check("R12 sout cleared", serial_out_o, 0);
  endtask

  task automatic t_ext();
    logic t; logic [7:0] v; logic a;
    ext_req_i = 1;
    sample_once(t, v, a);
    check("R14 no take while disabled", t, 0);
    pulse_ei();
    check("R10 ei sets enable", stat_rdata_o[3], 1);
    sample_once(t, v, a);
    check("R14 ext take", t, 1);
    check("R14 ack pulse", a, 1);
    check("R3 ext vector", v, 8'h00);
    check("R10 take clears enable", stat_rdata_o[3], 0);
    ext_req_i = 0; tick();
    check("R4 take lasts one cycle", take_o, 0);
  endtask

  task automatic t_priority();
    logic t; logic [7:0] v; logic a;
    rq_lo_i = 1; rq_mid_i = 1; ext_req_i = 1;
    pulse_ei();
    sample_once(t, v, a);
    check("R2 middle beats low and ext", v, 8'h34);
    check("R2 no ack for restart", a, 0);
    rq_mid_i = 0; pulse_ei();
    sample_once(t, v, a);
    check("R2 R3 low vector", v, 8'h2C);
    rq_lo_i = 0; pulse_ei();
    sample_once(t, v, a);
    check("R2 ext last", {t, a}, 2'b11);
    ext_req_i = 0;
  endtask

  task automatic t_gating();
    logic t; logic [7:0] v; logic a;
    pulse_ei();
    rq_lo_i = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R4 no take without sample", take_o, 0);
    end
    rq_lo_i = 0;
    sample_once(t, v, a);
    check("R7 dropped level ignored", t, 0);
    check("R7 enable kept", stat_rdata_o[3], 1);
  endtask

  task automatic t_hi_edge();
    logic t; logic [7:0] v; logic a;
    write_mask(8'h0C);
    rq_hi_i = 1; tick(); rq_hi_i = 0; tick();
    check("R5 masked edge captured", stat_rdata_o[6], 1);
    sample_once(t, v, a);
    check("R5 masked not taken", t, 0);
    write_mask(8'h08);
    sample_once(t, v, a);
    check("R5 R3 high vector", {t, v}, {1'b1, 8'h3C});
    check("R6 cleared on service", stat_rdata_o[6], 0);
    rq_hi_i = 1; tick(); rq_hi_i = 0; tick();
    check("R5 recapture", stat_rdata_o[6], 1);
    write_mask(8'h10);
    check("R6 cleared by mask write", stat_rdata_o[6], 0);
    check("R12 masks kept on clear write", stat_rdata_o[2:0], 0);
  endtask

  task automatic t_nmi();
    logic t; logic [7:0] v; logic a;
    pulse_di();
    write_mask(8'h0F);
    nmi_i = 1; tick();
    sample_once(t, v, a);
    check("R8 R3 nmi taken masked+disabled", {t, v}, {1'b1, 8'h24});
    sample_once(t, v, a);
    check("R8 held line not retaken", t, 0);
    nmi_i = 0; tick(); nmi_i = 1; tick();
    sample_once(t, v, a);
    check("R8 rearmed take", {t, v}, {1'b1, 8'h24});
    nmi_i = 0; tick();
    nmi_i = 1; tick(); nmi_i = 0; tick();
    sample_once(t, v, a);
    check("R9 short pulse dropped", t, 0);
    pulse_rd();
  endtask

  task automatic t_nmi_save();
    logic t; logic [7:0] v; logic a;
    pulse_ei();
    nmi_i = 1; tick();
    sample_once(t, v, a);
    check("R11 taken", t, 1);
    check("R11 saved enable shown", stat_rdata_o[3], 1);
    pulse_rd();
    check("R11 live enable after read", stat_rdata_o[3], 0);
    nmi_i = 0; tick();
  endtask

  task automatic t_take_vs_ei();
    logic t; logic [7:0] v; logic a;
    pulse_ei();
    ext_req_i = 1;
    ei_i = 1;
    sample_once(t, v, a);
    ei_i = 0; ext_req_i = 0;
    check("R10 take with ei", t, 1);
    check("R10 take wins over ei", stat_rdata_o[3], 0);
  endtask

  task automatic t_status();
    write_mask(8'h0A);
    serial_in_i = 1; rq_lo_i = 1; rq_mid_i = 1;
    tick();
    check("R13 status layout", stat_rdata_o, 8'hB2);
    serial_in_i = 0; rq_lo_i = 0; rq_mid_i = 0;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; nmi_i = 0; rq_hi_i = 0; rq_mid_i = 0; rq_lo_i = 0;
    ext_req_i = 0; sample_i = 0; ei_i = 0; di_i = 0; mask_wr_i = 0;
    mask_wdata_i = 0; stat_rd_i = 0; serial_in_i = 0;
    repeat (4) tick();
    rst_n = 1;
    repeat (4) tick();
    t_reset();
    t_mask_word();
    t_ext();
    t_priority();
    t_gating();
    t_hi_edge();
    t_nmi();
    t_nmi_save();
    t_take_vs_ei();
    t_status();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule